// File: doc/BRIEF.md
# Power-on Reset Sequencer with Cause Logging

This block produces the chip-wide reset and one reset line per power domain, and keeps a record of why the last resets happened. It watches a set of cold-reset sources and a set of warm-reset sources. Any source that goes high forces the chip-wide reset on at once, without waiting for a clock. When every source has gone low again, the release is passed through a two-flop synchronizer. The reset is then held for a further number of cycles taken from a delay register that software can write. This gives the supplies and the oscillator time to settle.

Domains named in a parameter mask stay in reset after the chip-wide reset ends. Each leaves reset only when software sets its release bit. The other domains simply follow the chip-wide reset. A global status register gives each warm source its own bit, while every cold source sets one shared bit. A status register per domain records whether that domain saw a cold reset, a warm reset or a software-requested reset. Software clears these bits by writing ones to them. A small write/read register port carries all software access. Writes are accepted only while the chip-wide reset is off.

Top module: `pwr_rst_seq`

## Requirements
- R1: Whenever any cold or warm source is high, `grst_o` and every bit of `dom_rst_o` are high, with no clock edge needed; after power-on with a cold source held, all reset outputs read 1.
- R2: After the last source goes low, `grst_o` falls right after the (D+4)-th rising clock edge, where D is the delay register value. That is 2 edges of synchronizer, 1 load edge, D count edges and 1 exit edge.
- R3: The delay register sits at address 0 and is 16 bits wide. A cold reset sets it to 0x00FF, a warm reset leaves it unchanged, and software writes replace it.
- R4: The release register sits at address 1, with bit d belonging to domain d. Domains in HELD_MASK (default domains 0 and 1) keep `dom_rst_o[d]` high until their release bit is 1. Release bits of other domains cannot be set and read 0, and those domains' reset lines equal `grst_o`.
- R5: Writing 0 to the release bit of a released held domain puts that domain back into reset on the next edge. It also sets bit 2 (software cause) of that domain's status register.
- R6: The global status register sits at address 2. Bit 0 is the shared cold bit and bit 1+i belongs to warm source i. A cold reset leaves it reading exactly 0x0001.
- R7: A warm reset keeps the bits already set in the global status register and adds the bit of each warm source that was high.
- R8: The status register of domain d sits at address 3+d. Bit 0 means cold, bit 1 means warm and bit 2 means software. A cold reset sets it to 0b001, and a warm reset ORs in 0b010.
- R9: The status registers are write-1-to-clear. A 1 clears the bit in that position and a 0 leaves it unchanged.
- R10: Bus writes made while `grst_o` is high have no effect on any register.
- R11: Read data is registered. The value at the address presented before a rising edge appears on `bus_rdata_o` after that edge, and unmapped addresses read 0.
- R12: Every cold or warm reset returns all release bits to 0, so held domains are again in reset once the chip-wide reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_src_i | input | N_COLD | Cold-reset sources, active high, asserted asynchronously |
| warm_src_i | input | N_WARM | Warm-reset sources, active high, asserted asynchronously |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register address for both read and write |
| bus_wdata_i | input | DATA_W | Register write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| grst_o | output | 1 | Chip-wide reset, active high |
| dom_rst_o | output | N_DOM | Per-domain reset lines, active high |

## Verification
On every cycle the assertions check the following:
- an active source always forces the chip-wide reset on;
- the chip-wide reset only falls after a quiet cycle;
- held domains are never out of reset while the chip-wide reset is on, and free domains track it;
- a cold reset reloads the delay value and leaves only the cold status bit;
- writes are locked out during reset.

Only the bench scenarios can show the rest, because those results depend on the sequence of stimulus. This covers the exact stretch length for two different programmed delays. It also covers release and re-hold of held domains with the software cause bit, write-1-to-clear versus write-0 behaviour, and warm bits building up over several warm resets while a cold reset wipes them. The bench also shows that a write made during the stretch is lost.

// File: rtl/rsq_pkg.sv
`timescale 1ns/1ps
package rsq_pkg;

  typedef enum logic [1:0] {
    ST_HOLD    = 2'd0,
    ST_STRETCH = 2'd1,
    ST_RUN     = 2'd2
  } seq_state_e;

  // register addresses
  localparam int unsigned REG_DELAY   = 0;
  localparam int unsigned REG_RELEASE = 1;
  localparam int unsigned REG_GSTAT   = 2;
  localparam int unsigned REG_DSTAT0  = 3;

  // domain status bit positions
  localparam int unsigned DST_COLD = 0;
  localparam int unsigned DST_WARM = 1;
  localparam int unsigned DST_SOFT = 2;
  localparam int unsigned DST_W    = 3;

endpackage

// File: rtl/rsq_sync.sv
`timescale 1ns/1ps
// Per-bit reset synchronizer: set at once by its source, released
// through two flops.
module rsq_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] held_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] ff_q;

    always_ff @(posedge clk or posedge src_i[g]) begin
      if (src_i[g]) ff_q <= 2'b11;
      else          ff_q <= {ff_q[0], 1'b0};
    end

    assign held_o[g] = ff_q[1];
  end

endmodule

// File: rtl/rsq_stretch.sv
`timescale 1ns/1ps
// Holds the chip-wide reset while sources are active, then counts the
// programmed delay down before entering the run state.
module rsq_stretch
  import rsq_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             src_any_i,
  input  logic             hold_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             run_o
);

  seq_state_e       st_q;
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk or posedge src_any_i) begin
    if (src_any_i) begin
      st_q  <= ST_HOLD;
      cnt_q <= '0;
    end else if (hold_i) begin
      st_q  <= ST_HOLD;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_HOLD: begin
          st_q  <= ST_STRETCH;
          cnt_q <= dly_i;
        end
        ST_STRETCH: begin
          if (cnt_q == '0) st_q  <= ST_RUN;
          else             cnt_q <= cnt_q - 1'b1;
        end
        ST_RUN:  st_q <= ST_RUN;
        default: st_q <= ST_HOLD;
      endcase
    end
  end

  assign run_o = (st_q == ST_RUN);

endmodule

// File: rtl/rsq_regs.sv
`timescale 1ns/1ps
// Software-visible registers: delay, release bits, global and per-domain
// cause logs, registered read mux.
module rsq_regs
  import rsq_pkg::*;
#(
  parameter int                N_WARM    = 3,
  parameter int                N_DOM     = 4,
  parameter logic [N_DOM-1:0]  HELD_MASK = 4'b0011,
  parameter int                DLY_W     = 16,
  parameter logic [DLY_W-1:0]  DLY_INIT  = 16'h00FF,
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 16
) (
  input  logic              clk,
  input  logic              cold_hold_i,
  input  logic [N_WARM-1:0] warm_hold_i,
  input  logic              run_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [DLY_W-1:0]  dly_o,
  output logic [N_DOM-1:0]  rel_o,
  output logic [N_WARM:0]   gstat_o
);

  logic             wr_ok;
  logic             wr_delay, wr_rel, wr_gstat;
  logic             any_hold, warm_any;
  logic [DLY_W-1:0] dly_q;
  logic [N_DOM-1:0] rel_q;
  logic [N_WARM:0]  gstat_q;
  logic [DST_W-1:0] dstat_w [N_DOM];
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  assign wr_ok    = bus_we_i & run_i;
  assign wr_delay = wr_ok && (bus_addr_i == ADDR_W'(REG_DELAY));
  assign wr_rel   = wr_ok && (bus_addr_i == ADDR_W'(REG_RELEASE));
  assign wr_gstat = wr_ok && (bus_addr_i == ADDR_W'(REG_GSTAT));
  assign warm_any = |warm_hold_i;
  assign any_hold = cold_hold_i | warm_any;

  // stretch length: restored only by a cold reset
  always_ff @(posedge clk) begin
    if (cold_hold_i)   dly_q <= DLY_INIT;
    else if (wr_delay) dly_q <= bus_wdata_i[DLY_W-1:0];
  end

  // release bits: only held domains are writable
  always_ff @(posedge clk) begin
    if (any_hold)    rel_q <= '0;
    else if (wr_rel) rel_q <= bus_wdata_i[N_DOM-1:0] & HELD_MASK;
  end

  // global cause log: cold wipes and sets the shared bit, warm accumulates
  always_ff @(posedge clk) begin
    if (cold_hold_i) begin
      gstat_q <= {{N_WARM{1'b0}}, 1'b1};
    end else begin
      gstat_q <= (gstat_q | {warm_hold_i, 1'b0})
               & ~(wr_gstat ? bus_wdata_i[N_WARM:0] : {(N_WARM+1){1'b0}});
    end
  end

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    logic             drop;
    logic             clr_hit;
    logic [DST_W-1:0] st_q;

    assign drop    = wr_rel && HELD_MASK[d] && rel_q[d] && !bus_wdata_i[d];
    assign clr_hit = wr_ok && (bus_addr_i == ADDR_W'(REG_DSTAT0 + d));

    always_ff @(posedge clk) begin
      if (cold_hold_i) begin
        st_q <= DST_W'(1) << DST_COLD;
      end else begin
        st_q <= (st_q | (DST_W'(warm_any) << DST_WARM) | (DST_W'(drop) << DST_SOFT))
              & ~(clr_hit ? bus_wdata_i[DST_W-1:0] : {DST_W{1'b0}});
      end
    end

    assign dstat_w[d] = st_q;
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr_i == ADDR_W'(REG_DELAY))   rd_mux = DATA_W'(dly_q);
    if (bus_addr_i == ADDR_W'(REG_RELEASE)) rd_mux = DATA_W'(rel_q);
    if (bus_addr_i == ADDR_W'(REG_GSTAT))   rd_mux = DATA_W'(gstat_q);
    for (int d = 0; d < N_DOM; d++) begin
      if (bus_addr_i == ADDR_W'(REG_DSTAT0 + d)) rd_mux = DATA_W'(dstat_w[d]);
    end
  end

  always_ff @(posedge clk) begin
    rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;
  assign dly_o       = dly_q;
  assign rel_o       = rel_q;
  assign gstat_o     = gstat_q;

endmodule

// File: rtl/pwr_rst_seq.sv
`timescale 1ns/1ps
module pwr_rst_seq
  import rsq_pkg::*;
#(
  parameter int                N_COLD    = 2,
  parameter int                N_WARM    = 3,
  parameter int                N_DOM     = 4,
  parameter logic [N_DOM-1:0]  HELD_MASK = 4'b0011,
  parameter int                DLY_W     = 16,
  parameter logic [DLY_W-1:0]  DLY_INIT  = 16'h00FF,
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 16
) (
  input  logic              clk,
  input  logic [N_COLD-1:0] cold_src_i,
  input  logic [N_WARM-1:0] warm_src_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              grst_o,
  output logic [N_DOM-1:0]  dom_rst_o
);

  logic [N_COLD-1:0] cold_h;
  logic [N_WARM-1:0] warm_h;
  logic              cold_hold, hold_any, src_any, run;
  logic [DLY_W-1:0]  dly;
  logic [N_DOM-1:0]  rel;
  logic [N_WARM:0]   gstat;

  assign src_any = (|cold_src_i) | (|warm_src_i);

  rsq_sync #(.W(N_COLD)) u_cold_sync (
    .clk    (clk),
    .src_i  (cold_src_i),
    .held_o (cold_h)
  );

  rsq_sync #(.W(N_WARM)) u_warm_sync (
    .clk    (clk),
    .src_i  (warm_src_i),
    .held_o (warm_h)
  );

  assign cold_hold = |cold_h;
  assign hold_any  = cold_hold | (|warm_h);

  rsq_stretch #(.DLY_W(DLY_W)) u_stretch (
    .clk       (clk),
    .src_any_i (src_any),
    .hold_i    (hold_any),
    .dly_i     (dly),
    .run_o     (run)
  );

  rsq_regs #(
    .N_WARM    (N_WARM),
    .N_DOM     (N_DOM),
    .HELD_MASK (HELD_MASK),
    .DLY_W     (DLY_W),
    .DLY_INIT  (DLY_INIT),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) u_regs (
    .clk         (clk),
    .cold_hold_i (cold_hold),
    .warm_hold_i (warm_h),
    .run_i       (run),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .dly_o       (dly),
    .rel_o       (rel),
    .gstat_o     (gstat)
  );

  assign grst_o    = ~run;
  assign dom_rst_o = {N_DOM{~run}} | (HELD_MASK & ~rel);

endmodule

// File: rtl/rsq_chk.sv
`timescale 1ns/1ps
module rsq_chk #(
  parameter int                N_COLD    = 2,
  parameter int                N_WARM    = 3,
  parameter int                N_DOM     = 4,
  parameter logic [N_DOM-1:0]  HELD_MASK = 4'b0011,
  parameter int                DLY_W     = 16,
  parameter logic [DLY_W-1:0]  DLY_INIT  = 16'h00FF
) (
  input logic              clk,
  input logic [N_COLD-1:0] cold_src,
  input logic [N_WARM-1:0] warm_src,
  input logic              grst,
  input logic [N_DOM-1:0]  dom_rst,
  input logic              cold_hold,
  input logic [DLY_W-1:0]  dly_q,
  input logic [N_WARM:0]   gstat_q
);

  logic armed = 1'b0;
  logic src_any;

  assign src_any = (|cold_src) | (|warm_src);

  always_ff @(posedge clk) begin
    if (cold_hold) armed <= 1'b1;
  end

  a_r1_src_forces_rst: assert property (@(posedge clk) disable iff (!armed)
    src_any |-> grst);

  a_r2_release_after_quiet: assert property (@(posedge clk) disable iff (!armed)
    $fell(grst) |-> (!src_any && $past(!src_any)));

  a_r4_held_in_global: assert property (@(posedge clk) disable iff (!armed)
    grst |-> (&dom_rst));

  a_r4_free_follow: assert property (@(posedge clk) disable iff (!armed)
    (dom_rst & ~HELD_MASK) == ({N_DOM{grst}} & ~HELD_MASK));

  a_r3_cold_reload: assert property (@(posedge clk) disable iff (!armed)
    cold_hold |=> (dly_q == DLY_INIT));

  a_r6_cold_log: assert property (@(posedge clk) disable iff (!armed)
    cold_hold |=> (gstat_q == {{N_WARM{1'b0}}, 1'b1}));

  a_r10_write_locked: assert property (@(posedge clk) disable iff (!armed)
    ($past(grst) && !$past(cold_hold)) |-> $stable(dly_q));

endmodule

bind pwr_rst_seq rsq_chk #(
  .N_COLD    (N_COLD),
  .N_WARM    (N_WARM),
  .N_DOM     (N_DOM),
  .HELD_MASK (HELD_MASK),
  .DLY_W     (DLY_W),
  .DLY_INIT  (DLY_INIT)
) u_chk (
  .clk       (clk),
  .cold_src  (cold_src_i),
  .warm_src  (warm_src_i),
  .grst      (grst_o),
  .dom_rst   (dom_rst_o),
  .cold_hold (cold_hold),
  .dly_q     (dly),
  .gstat_q   (gstat)
);

// File: tb/sim_pwr_rst_seq.sv
`timescale 1ns/1ps
module sim_pwr_rst_seq;

  localparam int HELD = 4'b0011;

  logic        clk = 1'b0;
  logic [1:0]  cold_src;
  logic [2:0]  warm_src;
  logic        we;
  logic [3:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        grst;
  logic [3:0]  dom_rst;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  pwr_rst_seq u0 (
    .clk         (clk),
    .cold_src_i  (cold_src),
    .warm_src_i  (warm_src),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .grst_o      (grst),
    .dom_rst_o   (dom_rst)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  quiet  = 0;
  int  m_dly  = 255;
  bit  m_grst = 1'b1;
  int  m_rel  = 0;
  int  m_g    = 0;
  int  m_ds[4];
  int  m_rd   = 0;
  int  cyc    = 0;

  function automatic int model_read(input int a);
    if (a == 0) return m_dly;
    if (a == 1) return m_rel;
    if (a == 2) return m_g;
    if (a >= 3 && a <= 6) return m_ds[a-3];
    return 0;
  endfunction

  always @(posedge clk) begin
    bit src;
    src  = (|cold_src) || (|warm_src);
    cyc++;
    m_rd = model_read(int'(addr));
    if (we && !m_grst && !src) begin
      case (int'(addr))
        0: m_dly = int'(wdata);
        1: begin
          for (int d = 0; d < 4; d++)
            if (HELD[d] && m_rel[d] && !wdata[d]) m_ds[d] = m_ds[d] | 4;
          m_rel = int'(wdata[3:0]) & HELD;
        end
        2: m_g = m_g & ~int'(wdata[3:0]);
        3, 4, 5, 6: m_ds[int'(addr)-3] = m_ds[int'(addr)-3] & ~int'(wdata[2:0]);
        default: ;
      endcase
    end
    if (|cold_src) begin
      m_g = 1; m_rel = 0; m_dly = 255;
      for (int d = 0; d < 4; d++) m_ds[d] = 1;
    end else if (|warm_src) begin
      for (int i = 0; i < 3; i++) if (warm_src[i]) m_g = m_g | (1 << (i + 1));
      for (int d = 0; d < 4; d++) m_ds[d] = m_ds[d] | 2;
      m_rel = 0;
    end
    if (src) quiet = 0;
    else if (quiet < 1000000) quiet++;
    m_grst = (quiet < m_dly + 4);
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (cyc >= 3) begin
      chk("R2 per-cycle grst", int'(grst), int'(m_grst));
      chk("R4 per-cycle dom_rst", int'(dom_rst),
          (m_grst ? 15 : 0) | (HELD & ~m_rel));
      chk("R11 per-cycle rdata", int'(rdata), m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input int v);
    @(negedge clk); #1;
    we = 1'b1; addr = 4'(a); wdata = 16'(v);
    @(negedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    @(negedge clk); #1;
    addr = 4'(a);
    @(negedge clk); #1;
    chk(tag, int'(rdata), exp);
  endtask

  task automatic measure_release(output int n);
    n = 0;
    while (grst && n < 2000) begin
      @(negedge clk);
      n++;
    end
    #1;
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R2 watchdog got=hung exp=released");
    finish_up();
  end

  initial begin
    int n;
    cold_src = 2'b01; warm_src = '0; we = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 reset state grst", int'(grst), 1);
    chk("R1 reset state dom_rst", int'(dom_rst), 15);

    @(negedge clk); #1; cold_src = '0;
    measure_release(n);
    chk("R2 stretch with power-on delay", n, 255 + 4);
    chk("R4 held domains still in reset", int'(dom_rst), 4'b0011);

    rd_chk(0, 16'h00FF, "R3 delay after cold");
    rd_chk(2, 1, "R6 global status after cold");
    for (int d = 0; d < 4; d++) rd_chk(3 + d, 1, "R8 domain status after cold");
    rd_chk(1, 0, "R4 release bits after cold");
    rd_chk(15, 0, "R11 unmapped address");

    wr(1, 1);
    chk("R4 domain0 released only", int'(dom_rst), 4'b0010);
    wr(1, 15);
    rd_chk(1, 3, "R4 only held release bits stick");
    chk("R4 all domains out of reset", int'(dom_rst), 0);

    wr(1, 2);
    chk("R5 domain0 back in reset", int'(dom_rst), 4'b0001);
    rd_chk(3, 5, "R5 software cause logged");
    rd_chk(4, 1, "R5 other domain untouched");

    wr(2, 0);
    rd_chk(2, 1, "R9 write zero keeps bit");
    wr(2, 1);
    rd_chk(2, 0, "R9 write one clears bit");
    wr(3, 4);
    rd_chk(3, 1, "R9 domain soft bit cleared");

    wr(0, 5);
    rd_chk(0, 5, "R3 delay written");
    wr(1, 3);

    @(negedge clk); #1; warm_src = 3'b001;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 warm source forces reset", int'(dom_rst), 15);
    warm_src = '0;
    measure_release(n);
    chk("R2 stretch with delay 5", n, 5 + 4);
    chk("R12 held domains re-held", int'(dom_rst), 4'b0011);
    rd_chk(1, 0, "R12 release bits cleared");
    rd_chk(2, 2, "R7 warm source 0 logged");
    rd_chk(0, 5, "R3 delay kept over warm");

    @(negedge clk); #1; warm_src = 3'b100;
    repeat (2) @(negedge clk);
    #1; warm_src = '0;
    measure_release(n);
    rd_chk(2, 10, "R7 warm bits accumulate");
    rd_chk(3, 3, "R8 warm ORs into domain status");
    rd_chk(5, 3, "R8 free domain status");

    @(negedge clk); #1; warm_src = 3'b010;
    repeat (2) @(negedge clk);
    #1; warm_src = '0;
    repeat (2) @(negedge clk);
    wr(0, 16'h0033);
    wr(1, 3);
    measure_release(n);
    rd_chk(0, 5, "R10 delay write in reset ignored");
    chk("R10 release write in reset ignored", int'(dom_rst), 4'b0011);
    rd_chk(2, 14, "R7 third warm source added");

    @(negedge clk); #1; cold_src = 2'b10;
    repeat (3) @(negedge clk);
    #1; cold_src = '0;
    measure_release(n);
    chk("R2 cold restores default stretch", n, 255 + 4);
    rd_chk(2, 1, "R6 cold wipes warm bits");
    rd_chk(0, 16'h00FF, "R3 cold reloads delay");
    rd_chk(4, 1, "R8 cold domain status");
    wr(4, 7);
    rd_chk(4, 0, "R9 domain status fully cleared");

    repeat (3) @(negedge clk);
    finish_up();
  end

endmodule